// File: doc/BRIEF.md
# Multiplexed Expansion ROM Read Port

This block reads single bytes from a slow external ROM. The ROM hangs off one shared 8-bit bidirectional bus, and the address reaches it through external 8-bit holding latches. Two requesters, A and B, share the port. Each one raises a level request with a 20-bit byte address and holds it until it sees its own done pulse. The port serves one request at a time and does not pipeline. Each access loads the address into the external latches one byte per cycle, highest byte first. It then releases the bus, turns the ROM output on for a programmed number of cycles, and captures the byte the ROM returns.

The block has no configuration registers. Its configuration comes from straps: pull-down levels on the bus that the port samples in the first clock cycle after reset is released. One strap field gives the ROM window size, a power of two from 16 KB to 1 MB. The other gives the number of extra wait cycles the ROM needs. Address bits above the window are dropped, so accesses wrap inside the ROM. When the window is 64 KB or smaller, the high-byte latch phase is skipped.

Top module: `xrom_port`

## Requirements
- R1: In the first cycle after reset is released, the port samples `busIn[2:0]` as the size code, giving a window of 16 KB << code. Code 7 is treated as 6 (1 MB). A high-byte latch phase happens only for codes 3 and above.
- R2: In the same cycle the port samples `busIn[5:3]` as the wait count W (0 to 7). `romOe` is then high for exactly W+1 consecutive cycles per access.
- R3: The address is ANDed with (window size − 1) before use. The returned byte is the ROM content at that wrapped address.
- R4: After a grant, the port drives the bus in consecutive cycles as follows. For codes of 3 and above, the first cycle has `latchHi` high with bus = {4'b0, addr[19:16]}. Then comes a cycle with `latchMid` high and bus = addr[15:8]. Then a cycle with `latchLo` high and bus = addr[7:0]. Each strobe is high only while `busOe` is high, and at most one strobe is high at a time.
- R5: Between the low-byte cycle and the first `romOe` cycle there is exactly one cycle in which both `busOe` and `romOe` are low.
- R6: The done pulse of the served requester is one cycle wide. It comes in the cycle right after the last `romOe` cycle, which is (high phase ? 1 : 0) + 5 + W cycles after the edge that accepts the request, and `rdData` holds the captured byte in that cycle.
- R7: When both requests are pending while the port is idle, A is served first. `doneA` and `doneB` are never high together.
- R8: A grant is held until the served requester's done pulse. A request that arrives while another access is running waits for it to finish.
- R9: `busOe` and `romOe` are never high in the same cycle.
- R10: During reset, all strobes, `busOe`, `romOe`, both done pulses and `rdData` are 0.
- R11: `rdData` changes only in a cycle where a done pulse is high, and holds its value between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqA | input | 1 | Requester A read request, held until `doneA` |
| addrA | input | 20 | Requester A byte address |
| reqB | input | 1 | Requester B read request, held until `doneB` |
| addrB | input | 20 | Requester B byte address |
| doneA | output | 1 | One-cycle completion pulse for A |
| doneB | output | 1 | One-cycle completion pulse for B |
| rdData | output | 8 | Last byte read from the ROM |
| busIn | input | 8 | Level seen on the shared bus (straps or ROM data) |
| busOut | output | 8 | Value the port drives on the shared bus |
| busOe | output | 1 | Port bus driver enable |
| latchHi | output | 1 | Strobe for the external address[19:16] latch |
| latchMid | output | 1 | Strobe for the external address[15:8] latch |
| latchLo | output | 1 | Strobe for the external address[7:0] latch |
| romOe | output | 1 | ROM output enable |

## Verification
Every access follows a fixed schedule once the request is accepted. The bench counts falling edges from that edge and expects a specific signal pattern in each cycle. If the high phase is present, cycle 1 is the high-byte strobe. The middle-byte and low-byte strobes come next, followed by one turnaround cycle. `romOe` is then high for W+1 cycles, and the done pulse follows at cycle (high?1:0)+5+W. The bench compares each falling edge against that pattern and also checks the total latency. It compares `rdData` in the done cycle, and again a few cycles later, against a ROM model evaluated at the wrapped address. The bench raises competing requests together, and also staggered by two cycles, then checks which done pulse comes first.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

  // Access phases of the port sequencer
  typedef enum logic [3:0] {
    S_SAMPLE,
    S_IDLE,
    S_HI,
    S_MID,
    S_LO,
    S_TURN,
    S_WAIT,
    S_CAP,
    S_DONE
  } phase_e;

  // Which address byte the datapath places on the bus
  typedef enum logic [1:0] {
    DRV_LO,
    DRV_MID,
    DRV_HI
  } drv_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sample;   // capture strap levels
    logic load;     // capture the granted address
    logic pickB;    // granted requester is B
    logic drive;    // put an address byte on the bus
    drv_e drvSel;   // which byte
    logic capture;  // capture ROM data from the bus
  } strobe_t;

endpackage

// File: rtl/xrom_dpath.sv
module xrom_dpath
  import xrom_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SIZE_W   = 3,
  parameter int WAIT_W   = 3,
  parameter int BASE_LOG = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [7:0]        busIn,
  output logic [7:0]        busOut,
  output logic [7:0]        rdData,
  output logic [WAIT_W-1:0] cfgWait,
  output logic              cfgBig
);

  localparam int MAX_CODE = ADDR_W - BASE_LOG;
  localparam int HI_W     = ADDR_W - 16;
  localparam int BIG_MIN  = 16 - BASE_LOG;

  logic [SIZE_W-1:0] sizeCode;
  logic [SIZE_W-1:0] strapSize;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] winMask;
  logic [7:0]        hiByte;

  assign strapSize = busIn[SIZE_W-1:0];
  assign winMask   = {ADDR_W{1'b1}} >> (MAX_CODE - int'(sizeCode));
  assign cfgBig    = int'(sizeCode) > BIG_MIN;

  generate
    if (HI_W < 8) begin : g_hiPad
      assign hiByte = {{(8 - HI_W){1'b0}}, addrReg[ADDR_W-1:16]};
    end else begin : g_hiFull
      assign hiByte = addrReg[ADDR_W-1:16];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sizeCode <= '0;
      cfgWait  <= '0;
      addrReg  <= '0;
      rdData   <= '0;
    end else begin
      if (stb.sample) begin
        sizeCode <= (int'(strapSize) > MAX_CODE) ? SIZE_W'(MAX_CODE) : strapSize;
        cfgWait  <= busIn[SIZE_W+WAIT_W-1:SIZE_W];
      end
      if (stb.load) begin
        addrReg <= (stb.pickB ? addrB : addrA) & winMask;
      end
      if (stb.capture) begin
        rdData <= busIn;
      end
    end
  end

  always_comb begin
    busOut = '0;
    if (stb.drive) begin
      unique case (stb.drvSel)
        DRV_HI:  busOut = hiByte;
        DRV_MID: busOut = addrReg[15:8];
        default: busOut = addrReg[7:0];
      endcase
    end
  end

endmodule

// File: rtl/xrom_ctrl.sv
module xrom_ctrl
  import xrom_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqA,
  input  logic              reqB,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgBig,
  output strobe_t           stb,
  output logic              busOe,
  output logic              latchHi,
  output logic              latchMid,
  output logic              latchLo,
  output logic              romOe,
  output logic              doneA,
  output logic              doneB
);

  phase_e            state, nextState;
  logic              ownerB, ownerBNext;
  logic [WAIT_W-1:0] waitCnt, waitNext;

  always_comb begin
    nextState  = state;
    ownerBNext = ownerB;
    waitNext   = waitCnt;
    stb        = '0;
    unique case (state)
      S_SAMPLE: begin
        stb.sample = 1'b1;
        nextState  = S_IDLE;
      end
      S_IDLE: begin
        if (reqA || reqB) begin
          stb.load   = 1'b1;
          stb.pickB  = !reqA;
          ownerBNext = !reqA;
          nextState  = cfgBig ? S_HI : S_MID;
        end
      end
      S_HI: begin
        stb.drive  = 1'b1;
        stb.drvSel = DRV_HI;
        nextState  = S_MID;
      end
      S_MID: begin
        stb.drive  = 1'b1;
        stb.drvSel = DRV_MID;
        nextState  = S_LO;
      end
      S_LO: begin
        stb.drive  = 1'b1;
        stb.drvSel = DRV_LO;
        nextState  = S_TURN;
      end
      S_TURN: begin
        waitNext  = cfgWait;
        nextState = (cfgWait == '0) ? S_CAP : S_WAIT;
      end
      S_WAIT: begin
        waitNext = waitCnt - 1'b1;
        if (waitCnt == WAIT_W'(1)) nextState = S_CAP;
      end
      S_CAP: begin
        stb.capture = 1'b1;
        nextState   = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_SAMPLE;
      ownerB  <= 1'b0;
      waitCnt <= '0;
    end else begin
      state   <= nextState;
      ownerB  <= ownerBNext;
      waitCnt <= waitNext;
    end
  end

  assign busOe    = stb.drive;
  assign latchHi  = (state == S_HI);
  assign latchMid = (state == S_MID);
  assign latchLo  = (state == S_LO);
  assign romOe    = (state == S_WAIT) || (state == S_CAP);
  assign doneA    = (state == S_DONE) && !ownerB;
  assign doneB    = (state == S_DONE) && ownerB;

endmodule

// File: rtl/xrom_port.sv
module xrom_port
  import xrom_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SIZE_W   = 3,
  parameter int WAIT_W   = 3,
  parameter int BASE_LOG = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              reqB,
  input  logic [ADDR_W-1:0] addrB,
  output logic              doneA,
  output logic              doneB,
  output logic [7:0]        rdData,
  input  logic [7:0]        busIn,
  output logic [7:0]        busOut,
  output logic              busOe,
  output logic              latchHi,
  output logic              latchMid,
  output logic              latchLo,
  output logic              romOe
);

  strobe_t           stb;
  logic [WAIT_W-1:0] cfgWait;
  logic              cfgBig;

  xrom_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqA     (reqA),
    .reqB     (reqB),
    .cfgWait  (cfgWait),
    .cfgBig   (cfgBig),
    .stb      (stb),
    .busOe    (busOe),
    .latchHi  (latchHi),
    .latchMid (latchMid),
    .latchLo  (latchLo),
    .romOe    (romOe),
    .doneA    (doneA),
    .doneB    (doneB)
  );

  xrom_dpath #(
    .ADDR_W   (ADDR_W),
    .SIZE_W   (SIZE_W),
    .WAIT_W   (WAIT_W),
    .BASE_LOG (BASE_LOG)
  ) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .addrA   (addrA),
    .addrB   (addrB),
    .busIn   (busIn),
    .busOut  (busOut),
    .rdData  (rdData),
    .cfgWait (cfgWait),
    .cfgBig  (cfgBig)
  );

endmodule

// File: rtl/xrom_chk.sv
module xrom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busOe,
  input logic       romOe,
  input logic       latchHi,
  input logic       latchMid,
  input logic       latchLo,
  input logic       doneA,
  input logic       doneB,
  input logic [7:0] rdData
);

  p_bus_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busOe && romOe));

  p_strobe_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latchHi || latchMid || latchLo) |-> busOe);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({latchHi, latchMid, latchLo}));

  p_hi_then_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latchHi |=> latchMid);

  p_mid_then_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latchMid |=> latchLo);

  p_lo_then_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latchLo |=> (!busOe && !romOe));

  p_roe_after_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(romOe) |-> !$past(busOe));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({doneA, doneB}));

  p_done_after_roe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (doneA || doneB) |-> ($past(romOe) && !romOe));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (doneA || doneB) |=> !(doneA || doneB));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdData) |-> (doneA || doneB));

endmodule

bind xrom_port xrom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busOe    (busOe),
  .romOe    (romOe),
  .latchHi  (latchHi),
  .latchMid (latchMid),
  .latchLo  (latchLo),
  .doneA    (doneA),
  .doneB    (doneB),
  .rdData   (rdData)
);

// File: tb/sim_xrom_port.sv
module sim_xrom_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqA = 1'b0, reqB = 1'b0;
  logic [19:0] addrA = '0, addrB = '0;
  logic        doneA, doneB, busOe, latchHi, latchMid, latchLo, romOe;
  logic [7:0]  rdData, busOut, busIn;

  logic [7:0]  strap = 8'h00;
  logic [7:0]  hiL = 8'h00, midL = 8'h00, loL = 8'h00;
  logic [19:0] curMask = 20'h03FFF;
  bit          curBig = 1'b0;
  int          curW = 0;
  int          nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] romByte(input logic [19:0] a);
    logic [7:0] hiPart;
    hiPart = {4'h0, a[19:16]} * 8'd29;
    return a[7:0] ^ (a[15:8] * 8'd5) ^ hiPart ^ 8'h3B;
  endfunction

  // ROM model: output when enabled, strap pull-downs otherwise
  assign busIn = romOe ? romByte({hiL[3:0], midL, loL} & curMask) : strap;

  // External address latches
  always @(negedge clk) begin
    if (latchHi)  hiL  = busOut;
    if (latchMid) midL = busOut;
    if (latchLo)  loL  = busOut;
  end

  xrom_port u0 (
    .clk(clk), .rst_n(rst_n),
    .reqA(reqA), .addrA(addrA), .reqB(reqB), .addrB(addrB),
    .doneA(doneA), .doneB(doneB), .rdData(rdData),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .latchHi(latchHi), .latchMid(latchMid), .latchLo(latchLo), .romOe(romOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input int code, input int wcode);
    int eff;
    eff     = (code > 6) ? 6 : code;
    strap   = {2'b00, 3'(wcode), 3'(code)};
    curMask = 20'((21'h4000 << eff) - 21'd1);
    curBig  = (eff > 2);
    curW    = wcode;
    reqA    = 1'b0;
    reqB    = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    chk({busOe, romOe, latchHi, latchMid, latchLo, doneA, doneB} == 7'b0 && rdData == 8'h00,
        "R10", "reset outputs", {busOe, romOe, latchHi, latchMid, latchLo, doneA, doneB, rdData}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitDone(output bit wasB, output int n);
    n = -1;
    wasB = 1'b0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (doneA || doneB) begin
        n = i;
        wasB = doneB;
        break;
      end
    end
  endtask

  task automatic doRead(input bit useB, input logic [19:0] addr);
    logic [19:0] m;
    logic [2:0]  lv;
    int          off, lat;
    bit          eSeq, eTurn, eRoe, eExcl, sawHi, gotB;
    logic [7:0]  got;
    m = addr & curMask;
    off = curBig ? 1 : 0;
    lat = -1;
    eSeq = 0; eTurn = 0; eRoe = 0; eExcl = 0; sawHi = 0; gotB = 0;
    @(negedge clk);
    if (useB) begin addrB = addr; reqB = 1'b1; end
    else      begin addrA = addr; reqA = 1'b1; end
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      lv = {latchHi, latchMid, latchLo};
      if (latchHi) sawHi = 1;
      if (busOe && romOe) eExcl = 1;
      if (curBig && i == 1) begin
        if (lv != 3'b100 || !busOe || busOut != {4'h0, m[19:16]}) eSeq = 1;
      end else if (i == 1 + off) begin
        if (lv != 3'b010 || !busOe || busOut != m[15:8]) eSeq = 1;
      end else if (i == 2 + off) begin
        if (lv != 3'b001 || !busOe || busOut != m[7:0]) eSeq = 1;
      end else begin
        if (lv != 3'b000) eSeq = 1;
        if (i == 3 + off) begin
          if (busOe || romOe) eTurn = 1;
        end else if (i <= 4 + off + curW) begin
          if (!romOe) eRoe = 1;
        end else if (romOe) begin
          eRoe = 1;
        end
      end
      if (doneA || doneB) begin
        lat = i;
        gotB = doneB;
        got = rdData;
        reqA = 1'b0;
        reqB = 1'b0;
        break;
      end
    end
    chk(lat == 5 + off + curW, "R6", "done latency", lat, 5 + off + curW);
    chk(sawHi == curBig, "R1", "high phase per size", sawHi, curBig);
    chk(!eSeq, "R4", "address byte sequence", eSeq, 0);
    chk(!eTurn, "R5", "turnaround cycle", eTurn, 0);
    chk(!eRoe, "R2", "romOe width", eRoe, 0);
    chk(!eExcl, "R9", "bus exclusive", eExcl, 0);
    chk(gotB == useB, "R7", "done owner", gotB, useB);
    chk(got == romByte(m), "R3", "wrapped read data", got, romByte(m));
    repeat (3) @(negedge clk);
    chk(rdData == got, "R11", "data hold", rdData, got);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int  ws[4] = '{0, 1, 3, 7};
    bit  wasB;
    int  n;
    logic [19:0] aList[4] = '{20'h00000, 20'hFFFFF, 20'hA5C3E, 20'h3_4A71};

    // Sweep every size code against a set of wait counts
    for (int code = 0; code < 8; code++) begin
      for (int wi = 0; wi < 4; wi++) begin
        doReset(code, ws[wi]);
        for (int k = 0; k < 4; k++) begin
          doRead(k[0], aList[k] ^ 20'(code * 20'h01111));
        end
      end
    end

    // R7: simultaneous requests, A wins
    doReset(3, 1);
    @(negedge clk);
    addrA = 20'h1_2345; addrB = 20'h0_6789;
    reqA = 1'b1; reqB = 1'b1;
    waitDone(wasB, n);
    chk(n > 0 && !wasB, "R7", "A served first", wasB, 0);
    chk(rdData == romByte(20'h1_2345 & curMask), "R7", "A data", rdData, romByte(20'h1_2345 & curMask));
    reqA = 1'b0;
    waitDone(wasB, n);
    chk(n > 0 && wasB, "R7", "B served second", wasB, 1);
    chk(rdData == romByte(20'h0_6789 & curMask), "R7", "B data", rdData, romByte(20'h0_6789 & curMask));
    reqB = 1'b0;

    // R8: B holds its grant while A arrives late
    @(negedge clk);
    addrB = 20'h1_FFFE; reqB = 1'b1;
    repeat (2) @(negedge clk);
    addrA = 20'h0_0101; reqA = 1'b1;
    waitDone(wasB, n);
    chk(n > 0 && wasB, "R8", "grant held by B", wasB, 1);
    reqB = 1'b0;
    waitDone(wasB, n);
    chk(n > 0 && !wasB, "R8", "A served after B", wasB, 0);
    chk(rdData == romByte(20'h0_0101 & curMask), "R8", "A data after wait", rdData, romByte(20'h0_0101 & curMask));
    reqA = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule